// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

This block collects 64 level-sensitive peripheral request lines, grouped into two banks of 32, and turns them into three processor-facing signals: a normal interrupt request, a fast interrupt request and an idle wake-up. Each bank has a mask register and a route-select register. The route-select register sends each unmasked source to either the normal or the fast request. Software reads per-bank views of the raw, pending and fast-pending state through a small synchronous register port.

A table of 64 priority slots ties each slot to a source number. A read-only "top request" register names the pending, unmasked, normal-routed source held by the lowest-numbered valid slot. Software acknowledges a level source by clearing its mask bit. A control bit chooses whether every raw request can wake the processor or only the unmasked ones.

Addresses are byte addresses, and only bits above bit 1 are decoded. A read returns its data on `rdata_o` one clock after the request.

Top module: `prio_intc`

## Requirements
- R1: After reset, both mask registers, both route-select registers, the control register and every priority slot read 0. With all sources low, `irq_o`, `fiq_o` and `wake_o` are 0.
- R2: The bank 0 registers sit at base 0x000 and the bank 1 registers at base 0x09C. Within a bank the offsets are: +0x10 raw request (the `src_i` lines of that bank, bank 0 holding sources 0–31), +0x00 pending, +0x04 mask, +0x08 route-select, +0x0C fast-pending. The control register is at 0x014 and the top request register at 0x018.
- R3: Pending equals raw AND mask. `irq_o` is the OR of all pending bits.
- R4: Fast-pending equals raw AND mask AND route-select, where a route bit of 1 means fast and 0 means normal. `fiq_o` is the OR of all fast-pending bits.
- R5: Priority slot s is at 0x01C+4·s for s<32 and at 0x0B0+4·(s−32) for s≥32. Bit 31 is the slot's valid flag and bits 5:0 are its source number. All other bits read 0.
- R6: The top request register has bit 31 set and the source number in bits 30:16 for the lowest-indexed valid slot whose source is pending, unmasked and routed normal. It reads 0 when no slot qualifies. Its value follows the current state with no delay.
- R7: Clearing a source's mask bit removes that source from pending, fast-pending, the top request register and both request outputs.
- R8: When control bit 0 is 1, `wake_o` is the OR of raw AND mask. When it is 0, `wake_o` is the OR of all raw lines. The control register keeps only bit 0.
- R9: Reads from unmapped addresses return 0, and writes to them change no state.
- R10: Writes to the raw, pending, fast-pending and top request registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| src_i | input | 64 | Level-sensitive request lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle wake-up request |

## Verification
Requests are driven in both banks at once. The mask is set for only some of them, which separates the raw value from the pending value and bank 0 from bank 1. Some sources are routed fast, which shows whether the top request search skips them while `fiq_o` rises. The priority table is loaded with an invalid slot, a low slot pointing at a fast source and several valid normal slots, so that slot order is told apart from source order. Masks are then cleared one at a time, and the top request is seen to move to the next slot. Both wake modes are run with masked-only requests, which is the one case where the two modes give different outputs.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  // word offsets inside a bank
  localparam int OFF_PEND = 0;
  localparam int OFF_MASK = 1;
  localparam int OFF_LVL  = 2;
  localparam int OFF_FIQ  = 3;
  localparam int OFF_RAW  = 4;
  // global words
  localparam int CTRL_WORD = 5;
  localparam int HP_WORD   = 6;

  function automatic int bank_base_w(input int b);
    return (b == 0) ? 0 : 39;
  endfunction

  function automatic int slot_word(input int s, input int bw);
    return ((s / bw) == 0 ? 7 : 44) + (s % bw);
  endfunction
endpackage

// File: rtl/prio_intc_bank.sv
module prio_intc_bank #(
  parameter int W  = 32,
  parameter int AW = 10,
  parameter logic [AW-1:0] BASE_W = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  input  logic [W-1:0]  raw_i,
  output logic [W-1:0]  cand_o,
  output logic [W-1:0]  pend_o,
  output logic [W-1:0]  fiq_pend_o,
  output logic [W-1:0]  mask_o,
  output logic          rd_hit_o,
  output logic [W-1:0]  rd_data_o
);
  import prio_intc_pkg::*;

  localparam logic [AW-1:0] A_PEND = BASE_W + AW'(OFF_PEND);
  localparam logic [AW-1:0] A_MASK = BASE_W + AW'(OFF_MASK);
  localparam logic [AW-1:0] A_LVL  = BASE_W + AW'(OFF_LVL);
  localparam logic [AW-1:0] A_FIQ  = BASE_W + AW'(OFF_FIQ);
  localparam logic [AW-1:0] A_RAW  = BASE_W + AW'(OFF_RAW);

  logic [W-1:0] mask_q, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      lvl_q  <= '0;
    end else if (wr_i) begin
      if (waddr_i == A_MASK) mask_q <= wdata_i;
      if (waddr_i == A_LVL)  lvl_q  <= wdata_i;
    end
  end

  assign pend_o     = raw_i & mask_q;
  assign fiq_pend_o = pend_o & lvl_q;
  assign cand_o     = pend_o & ~lvl_q;
  assign mask_o     = mask_q;

  always_comb begin
    rd_hit_o  = 1'b1;
    rd_data_o = '0;
    if      (raddr_i == A_PEND) rd_data_o = pend_o;
    else if (raddr_i == A_MASK) rd_data_o = mask_q;
    else if (raddr_i == A_LVL)  rd_data_o = lvl_q;
    else if (raddr_i == A_FIQ)  rd_data_o = fiq_pend_o;
    else if (raddr_i == A_RAW)  rd_data_o = raw_i;
    else                        rd_hit_o  = 1'b0;
  end
endmodule

// File: rtl/prio_intc_ptab.sv
module prio_intc_ptab #(
  parameter int N  = 64,
  parameter int SW = 6,
  parameter int BW = 32,
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  input  logic [N-1:0]  cand_i,
  output logic          rd_hit_o,
  output logic [DW-1:0] rd_data_o,
  output logic          hp_vld_o,
  output logic [SW-1:0] hp_src_o
);
  import prio_intc_pkg::*;

  logic          vld_q [N];
  logic [SW-1:0] src_q [N];

  for (genvar s = 0; s < N; s++) begin : g_slot
    localparam logic [AW-1:0] A_SLOT = AW'(slot_word(s, BW));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        src_q[s] <= '0;
      end else if (wr_i && waddr_i == A_SLOT) begin
        vld_q[s] <= wdata_i[DW-1];
        src_q[s] <= wdata_i[SW-1:0];
      end
    end
  end

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_data_o = '0;
    for (int s = 0; s < N; s++) begin
      if (raddr_i == AW'(slot_word(s, BW))) begin
        rd_hit_o  = 1'b1;
        rd_data_o = {vld_q[s], {(DW-1-SW){1'b0}}, src_q[s]};
      end
    end
  end

  // descending scan: the lowest qualifying slot is assigned last
  always_comb begin
    hp_vld_o = 1'b0;
    hp_src_o = '0;
    for (int s = N - 1; s >= 0; s--) begin
      if (vld_q[s] && cand_i[src_q[s]]) begin
        hp_vld_o = 1'b1;
        hp_src_o = src_q[s];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int BANK_W  = 32,
  parameter int N_BANKS = 2,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int N_SRC   = BANK_W * N_BANKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              wake_o
);
  import prio_intc_pkg::*;

  localparam int AW    = ADDR_W - 2;
  localparam int SRC_W = $clog2(N_SRC);
  localparam int HP_SRC_W = 15;

  logic [AW-1:0] wa;
  logic          wr;
  logic          ctrl_q;

  assign wa = addr_i[ADDR_W-1:2];
  assign wr = req_i & we_i;

  logic [BANK_W-1:0] cand_b [N_BANKS];
  logic [BANK_W-1:0] pend_b [N_BANKS];
  logic [BANK_W-1:0] fiqp_b [N_BANKS];
  logic [BANK_W-1:0] mask_b [N_BANKS];
  logic [BANK_W-1:0] rd_b   [N_BANKS];
  logic [N_BANKS-1:0] hit_b;
  logic [N_SRC-1:0]  cand_all, pend_all, fiqp_all, mask_all;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    prio_intc_bank #(
      .W     (BANK_W),
      .AW    (AW),
      .BASE_W(AW'(bank_base_w(b)))
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr),
      .waddr_i   (wa),
      .wdata_i   (wdata_i[BANK_W-1:0]),
      .raddr_i   (wa),
      .raw_i     (src_i[b*BANK_W +: BANK_W]),
      .cand_o    (cand_b[b]),
      .pend_o    (pend_b[b]),
      .fiq_pend_o(fiqp_b[b]),
      .mask_o    (mask_b[b]),
      .rd_hit_o  (hit_b[b]),
      .rd_data_o (rd_b[b])
    );
    assign cand_all[b*BANK_W +: BANK_W] = cand_b[b];
    assign pend_all[b*BANK_W +: BANK_W] = pend_b[b];
    assign fiqp_all[b*BANK_W +: BANK_W] = fiqp_b[b];
    assign mask_all[b*BANK_W +: BANK_W] = mask_b[b];
  end

  logic              pt_hit;
  logic [DATA_W-1:0] pt_rd;
  logic              hp_vld;
  logic [SRC_W-1:0]  hp_src;

  prio_intc_ptab #(
    .N (N_SRC),
    .SW(SRC_W),
    .BW(BANK_W),
    .AW(AW),
    .DW(DATA_W)
  ) u_ptab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .waddr_i  (wa),
    .wdata_i  (wdata_i),
    .raddr_i  (wa),
    .cand_i   (cand_all),
    .rd_hit_o (pt_hit),
    .rd_data_o(pt_rd),
    .hp_vld_o (hp_vld),
    .hp_src_o (hp_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= 1'b0;
    else if (wr && wa == AW'(CTRL_WORD)) ctrl_q <= wdata_i[0];
  end

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int b = 0; b < N_BANKS; b++)
      if (hit_b[b]) rd_word = DATA_W'(rd_b[b]);
    if (pt_hit) rd_word = pt_rd;
    if (wa == AW'(CTRL_WORD)) rd_word = DATA_W'(ctrl_q);
    if (wa == AW'(HP_WORD))
      rd_word = {hp_vld, {(HP_SRC_W-SRC_W){1'b0}}, hp_src, 16'h0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_word;
  end

  assign irq_o  = |pend_all;
  assign fiq_o  = |fiqp_all;
  assign wake_o = ctrl_q ? |(src_i & mask_all) : |src_i;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_SRC  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_SRC-1:0]  src_i,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              wake_o
);
  // R3
  no_src_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (!irq_o && !fiq_o));

  // R4
  fiq_implies_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> irq_o);

  // R8
  irq_implies_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);

  // R8
  idle_no_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> !wake_o);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i >= ADDR_W'('h130)) |=> (rdata_o == '0));

  // R6
  hp_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'('h018) && !irq_o) |=> (rdata_o == '0));
endmodule

bind prio_intc prio_intc_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .N_SRC (N_SRC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .src_i  (src_i),
  .irq_o  (irq_o),
  .fiq_o  (fiq_o),
  .wake_o (wake_o)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic        irq, fiq, wake;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_intc u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  // reference state
  logic [63:0] m_mask = '0, m_lvl = '0;
  bit          m_ctrl = 1'b0;
  bit          m_pv [64];
  int          m_ps [64];

  function automatic int slot_of(input logic [11:0] a);
    if (a >= 12'h01C && a <= 12'h098) return (a - 12'h01C) / 4;
    if (a >= 12'h0B0 && a <= 12'h12C) return 32 + (a - 12'h0B0) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] m_hp();
    for (int s = 0; s < 64; s++)
      if (m_pv[s] && src[m_ps[s]] && m_mask[m_ps[s]] && !m_lvl[m_ps[s]])
        return 32'h8000_0000 | (32'(m_ps[s]) << 16);
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [63:0] p;
    int s;
    p = src & m_mask;
    case (a)
      12'h000: return p[31:0];
      12'h004: return m_mask[31:0];
      12'h008: return m_lvl[31:0];
      12'h00C: return (p & m_lvl) >> 0;
      12'h010: return src[31:0];
      12'h014: return {31'h0, m_ctrl};
      12'h018: return m_hp();
      12'h09C: return p[63:32];
      12'h0A0: return m_mask[63:32];
      12'h0A4: return m_lvl[63:32];
      12'h0A8: return p[63:32] & m_lvl[63:32];
      12'h0AC: return src[63:32];
      default: ;
    endcase
    s = slot_of(a);
    if (s >= 0) return {m_pv[s], 25'h0, 6'(m_ps[s])};
    return 32'h0;
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [31:0] d);
    int s;
    case (a)
      12'h004: m_mask[31:0]  = d;
      12'h008: m_lvl[31:0]   = d;
      12'h0A0: m_mask[63:32] = d;
      12'h0A4: m_lvl[63:32]  = d;
      12'h014: m_ctrl        = d[0];
      default: begin
        s = slot_of(a);
        if (s >= 0) begin m_pv[s] = d[31]; m_ps[s] = int'(d[5:0]); end
      end
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the request outputs
  always begin
    @(posedge clk); #2;
    if (rst_n && !done) begin
      check("R3 irq_o", 32'(irq), 32'(|(src & m_mask)));
      check("R4 fiq_o", 32'(fiq), 32'(|(src & m_mask & m_lvl)));
      check("R8 wake_o", 32'(wake), 32'(m_ctrl ? |(src & m_mask) : |src));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 m_write(a, d);
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    logic [31:0] e;
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    e = m_read(a);
    @(posedge clk); #3 check(tag, rdata, e);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic rd_exp(input string tag, input logic [11:0] a, input logic [31:0] e);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #3 check(tag, rdata, e);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk); src = v;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 64; s++) begin m_pv[s] = 1'b0; m_ps[s] = 0; end
    #1;
    check("R1 irq_o in reset", 32'(irq), 32'h0);
    check("R1 wake_o in reset", 32'(wake), 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset values
    rd_exp("R1 mask0", 12'h004, 32'h0);
    rd_exp("R1 mask1", 12'h0A0, 32'h0);
    rd_exp("R1 lvl1", 12'h0A4, 32'h0);
    rd_exp("R1 ctrl", 12'h014, 32'h0);
    rd_exp("R1 slot0", 12'h01C, 32'h0);
    rd_exp("R1 hp", 12'h018, 32'h0);

    // R2 raw view per bank
    set_src(64'h8001_0000_0000_0300);
    rd_exp("R2 raw0", 12'h010, 32'h0000_0300);
    rd_exp("R2 raw1", 12'h0AC, 32'h8001_0000);
    rd_exp("R3 pend0 masked", 12'h000, 32'h0);

    // R3 pending
    wr(12'h004, 32'h0000_0100);
    wr(12'h0A0, 32'h0001_0000);
    rd_exp("R3 pend0", 12'h000, 32'h0000_0100);
    rd_exp("R3 pend1", 12'h09C, 32'h0001_0000);
    rd("R2 mask1 readback", 12'h0A0);

    // R4 fast routing of source 48
    wr(12'h0A4, 32'h0001_0000);
    rd_exp("R4 fiqp1", 12'h0A8, 32'h0001_0000);
    rd_exp("R4 fiqp0", 12'h00C, 32'h0);

    // R5 priority slots
    wr(12'h01C, 32'h8000_0030);          // slot0 -> 48 (fast, skipped)
    wr(12'h020, 32'h0000_0009);          // slot1 invalid -> 9
    wr(12'h030, 32'h8000_0008);          // slot5 -> 8
    wr(12'h0D0, 32'hFFFF_FFBF);          // slot40 -> 63
    rd_exp("R5 slot0", 12'h01C, 32'h8000_0030);
    rd_exp("R5 slot40 upper bits", 12'h0D0, 32'h8000_003F);
    rd("R5 slot1", 12'h020);

    // R6 top request
    rd_exp("R6 hp slot5", 12'h018, 32'h8008_0000);
    wr(12'h0A0, 32'h8001_0000);
    rd_exp("R6 slot order over source", 12'h018, 32'h8008_0000);

    // R7 acknowledge by mask clear
    wr(12'h004, 32'h0);
    rd_exp("R7 pend0 cleared", 12'h000, 32'h0);
    rd_exp("R7 hp moves", 12'h018, 32'h803F_0000);
    wr(12'h0A0, 32'h8000_0000);
    rd_exp("R7 fiqp1 cleared", 12'h0A8, 32'h0);

    // R6 newly valid lower slot wins
    wr(12'h020, 32'h8000_0009);
    wr(12'h004, 32'h0000_0200);
    rd_exp("R6 slot1 wins", 12'h018, 32'h8009_0000);

    // R8 wake modes
    wr(12'h014, 32'hFFFF_FFFF);
    rd_exp("R8 ctrl bit0 only", 12'h014, 32'h1);
    wr(12'h004, 32'h0);
    wr(12'h0A0, 32'h0);
    set_src(64'h0000_0010_0000_0004);
    @(posedge clk); #2 check("R8 masked-only no wake", 32'(wake), 32'h0);
    wr(12'h014, 32'h0);
    @(posedge clk); #2 check("R8 raw wake", 32'(wake), 32'h1);
    set_src(64'h0);
    rd_exp("R6 hp empty", 12'h018, 32'h0);

    // R9 unmapped
    wr(12'h200, 32'hDEAD_BEEF);
    rd_exp("R9 unmapped 0x200", 12'h200, 32'h0);
    rd_exp("R9 unmapped 0x130", 12'h130, 32'h0);
    wr(12'h0B0 - 12'h4, 32'hFFFF_FFFF);  // gap word 0x0AC is raw1, read-only
    rd("R9 mask0 intact", 12'h004);

    // R10 read-only registers
    set_src(64'h0000_0003_0000_0003);
    wr(12'h004, 32'h1);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0);
    wr(12'h018, 32'h0);
    rd_exp("R10 pend0", 12'h000, 32'h1);
    rd_exp("R10 raw0", 12'h010, 32'h3);
    rd_exp("R10 fiqp0", 12'h00C, 32'h0);
    rd("R10 hp", 12'h018);
    rd("R10 mask0", 12'h004);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule